// File: doc/BRIEF.md
# Receive Copy Engine

This block drains received packet bytes from a packet FIFO into memory on the command of software. A single 64-bit command word carries both the destination physical address and the number of bytes wanted. The engine accepts one byte per cycle from the FIFO and gathers the bytes into 8-byte memory words. Each word leaves through a valid/ready write port with byte strobes, so neither the address nor the length has to be word aligned. There is no address translation or protection.

A copy stops at whichever comes first: the requested length or the last byte of the current packet. It therefore never takes bytes from two packets. The engine records how many bytes it actually moved, whether the packet still has bytes waiting, and the class and checksum flags that arrived with the packet.

Software reads these results through a status port. A plain read answers on the next cycle. A waiting read holds its answer back until the engine is idle, so one read can replace a polling loop.

Top module: `rx_copy_engine`

## Requirements
- R1: A command is a 64-bit word with the destination address in bits [47:0] and the byte length in bits [63:48]. A command with a non-zero length accepted while idle starts a copy, and status bit 16 (busy) reads 1 until the copy ends.
- R2: Byte k of a copy goes to address A+k. Each memory word has a word-aligned address (bits [2:0] zero) and at least one strobe set. The byte for address X sits in data bits [8*(X mod 8)+7 : 8*(X mod 8)] with strobe bit X mod 8 set. Lanes not written carry zero data and a clear strobe.
- R3: A copy ends at the lesser of the requested length and the end of the current packet. It never consumes a byte after one marked last.
- R4: Status bits [15:0] give the number of bytes the most recent copy actually moved. Status bit 17 (ok) is set when that copy completes.
- R5: Status bit 18 (more) is 1 after a copy that stopped on its length with bytes of the packet left, and 0 after a copy that took the packet's last byte.
- R6: Status bits 19, 20 and 21 (IP, UDP, TCP) and bit 22 (checksum matched) repeat the class and checksum inputs that came with the last byte copied.
- R7: Status bits [31:24] show the packet count input.
- R8: A command that arrives while busy is dropped: it writes nothing to memory and leaves the running copy unchanged. The ok bit is cleared at once and stays 0 when that copy completes.
- R9: A zero-length command accepted while idle completes at once. Busy stays 0, the byte count reads 0 and ok reads 1.
- R10: While a copy waits on an empty FIFO, the FIFO ready output stays high and no memory word is offered.
- R11: A read with the wait input low returns the status on the cycle after the request.
- R12: A read with the wait input high is answered only once the engine is idle, and its answer shows busy 0.
- R13: After reset, busy, ok, more and the byte count are 0, and no memory write, FIFO ready or read response is active.
- R14: A memory word offered while ready is low holds its address, data and strobes until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command write strobe |
| cmd_i | input | 64 | Command: length [63:48], address [47:0] |
| rd_req_i | input | 1 | Status read request |
| rd_wait_i | input | 1 | Read waits for idle when high |
| rd_valid_o | output | 1 | Status read response valid |
| rd_status_o | output | 64 | Status word |
| pkt_valid_i | input | 1 | FIFO byte available |
| pkt_ready_o | output | 1 | Engine takes a FIFO byte |
| pkt_data_i | input | 8 | FIFO byte |
| pkt_last_i | input | 1 | Byte ends its packet |
| pkt_class_i | input | 3 | Class flags: bit 0 IP, bit 1 UDP, bit 2 TCP |
| pkt_csum_ok_i | input | 1 | Packet checksum matched |
| pkt_count_i | input | 8 | Packets held in the FIFO |
| mem_valid_o | output | 1 | Memory write valid |
| mem_ready_i | input | 1 | Memory write accepted |
| mem_addr_o | output | 48 | Word-aligned write address |
| mem_data_o | output | 64 | Write data |
| mem_strb_o | output | 8 | Byte strobes |

## Verification
The assertions assume software never starts a second read while a waiting read is still pending. They also assume the FIFO keeps its byte, last marker and flags steady while valid is high and ready is low. The stimulus keeps to both. It issues each read only after the previous response has arrived, and it changes the FIFO inputs only after the engine has taken a byte. Memory ready is throttled with a pseudo-random pattern, so stalled words occur often. Commands are sent while busy only in the test that checks they are dropped.

// File: rtl/rxce_pkg.sv
package rxce_pkg;
  localparam int STAT_W = 64;

  typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_FLUSH} rxce_st_e;

  typedef struct packed {
    logic [2:0] cls;   // [0] ip, [1] udp, [2] tcp
    logic       csum_ok;
  } rxce_tag_t;
endpackage

// File: rtl/rxce_ctrl.sv
module rxce_ctrl
  import rxce_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 16,
  parameter int WORD_B = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [ADDR_W+LEN_W-1:0] cmd_i,
  input  logic                    pkt_valid_i,
  input  logic                    pkt_last_i,
  input  rxce_tag_t               pkt_tag_i,
  input  logic                    flush_done_i,
  output logic                    take_o,
  output logic                    ready_o,
  output logic [ADDR_W-1:0]       byte_addr_o,
  output logic                    flush_o,
  output logic                    busy_o,
  output logic                    ok_o,
  output logic                    more_o,
  output rxce_tag_t               tag_o,
  output logic [LEN_W-1:0]        cnt_o
);
  localparam int LANE_W = $clog2(WORD_B);

  rxce_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q, cnt_q;
  logic              end_q, drop_q, ok_q, more_q;
  rxce_tag_t         tag_q;

  logic [LEN_W-1:0]  cmd_len;
  logic              byte_end, lane_top;

  assign cmd_len  = cmd_i[ADDR_W+LEN_W-1:ADDR_W];
  assign byte_end = pkt_last_i || (rem_q == LEN_W'(1));
  assign lane_top = addr_q[LANE_W-1:0] == LANE_W'(WORD_B-1);

  assign ready_o     = (st_q == ST_COPY);
  assign take_o      = ready_o && pkt_valid_i;
  assign flush_o     = (st_q == ST_FLUSH);
  assign busy_o      = (st_q != ST_IDLE);
  assign byte_addr_o = addr_q;
  assign ok_o        = ok_q;
  assign more_o      = more_q;
  assign tag_o       = tag_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      end_q  <= 1'b0;
      drop_q <= 1'b0;
      ok_q   <= 1'b0;
      more_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (cmd_valid_i) begin
          cnt_q <= '0;
          if (cmd_len == '0) begin
            ok_q <= 1'b1;
          end else begin
            addr_q <= cmd_i[ADDR_W-1:0];
            rem_q  <= cmd_len;
            ok_q   <= 1'b0;
            drop_q <= 1'b0;
            st_q   <= ST_COPY;
          end
        end
        ST_COPY: if (take_o) begin
          addr_q <= addr_q + ADDR_W'(1);
          rem_q  <= rem_q - LEN_W'(1);
          cnt_q  <= cnt_q + LEN_W'(1);
          tag_q  <= pkt_tag_i;
          if (byte_end) more_q <= !pkt_last_i;
          if (byte_end || lane_top) begin
            end_q <= byte_end;
            st_q  <= ST_FLUSH;
          end
        end
        ST_FLUSH: if (flush_done_i) begin
          if (end_q) begin
            st_q <= ST_IDLE;
            ok_q <= !drop_q;
          end else begin
            st_q <= ST_COPY;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      // command while busy: dropped, success flag cleared
      if (cmd_valid_i && busy_o) begin
        ok_q   <= 1'b0;
        drop_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxce_packer.sv
module rxce_packer #(
  parameter int ADDR_W = 48,
  parameter int WORD_B = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                take_i,
  input  logic [ADDR_W-1:0]   byte_addr_i,
  input  logic [7:0]          byte_i,
  input  logic                flush_i,
  input  logic                mem_ready_i,
  output logic                mem_valid_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [WORD_B*8-1:0] mem_data_o,
  output logic [WORD_B-1:0]   mem_strb_o
);
  localparam int LANE_W = $clog2(WORD_B);

  logic [WORD_B*8-1:0]      data_q;
  logic [WORD_B-1:0]        strb_q;
  logic [ADDR_W-LANE_W-1:0] wbase_q;
  logic [LANE_W-1:0]        lane;

  assign lane        = byte_addr_i[LANE_W-1:0];
  assign mem_valid_o = flush_i;
  assign mem_addr_o  = {wbase_q, LANE_W'(0)};
  assign mem_data_o  = data_q;
  assign mem_strb_o  = strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      strb_q  <= '0;
      wbase_q <= '0;
    end else if (flush_i && mem_ready_i) begin
      data_q <= '0;
      strb_q <= '0;
    end else if (take_i) begin
      if (strb_q == '0) wbase_q <= byte_addr_i[ADDR_W-1:LANE_W];
      data_q[lane*8 +: 8] <= byte_i;
      strb_q[lane]        <= 1'b1;
    end
  end
endmodule

// File: rtl/rxce_rdport.sv
module rxce_rdport #(
  parameter int STAT_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              rd_wait_i,
  input  logic              busy_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              rd_valid_o,
  output logic [STAT_W-1:0] rd_status_o
);
  logic wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q      <= 1'b0;
      rd_valid_o  <= 1'b0;
      rd_status_o <= '0;
    end else begin
      rd_valid_o <= 1'b0;
      if (rd_req_i && !rd_wait_i) begin
        rd_valid_o  <= 1'b1;
        rd_status_o <= stat_i;
      end else if (wait_q || (rd_req_i && rd_wait_i)) begin
        if (!busy_i) begin
          rd_valid_o  <= 1'b1;
          rd_status_o <= stat_i;
          wait_q      <= 1'b0;
        end else begin
          wait_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_copy_engine.sv
module rx_copy_engine
  import rxce_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 16,
  parameter int PCNT_W = 8,
  parameter int WORD_B = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cmd_valid_i,
  input  logic [ADDR_W+LEN_W-1:0] cmd_i,
  input  logic                    rd_req_i,
  input  logic                    rd_wait_i,
  output logic                    rd_valid_o,
  output logic [STAT_W-1:0]       rd_status_o,
  input  logic                    pkt_valid_i,
  output logic                    pkt_ready_o,
  input  logic [7:0]              pkt_data_i,
  input  logic                    pkt_last_i,
  input  logic [2:0]              pkt_class_i,
  input  logic                    pkt_csum_ok_i,
  input  logic [PCNT_W-1:0]       pkt_count_i,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [WORD_B*8-1:0]     mem_data_o,
  output logic [WORD_B-1:0]       mem_strb_o
);
  localparam int FLG_LSB = LEN_W;
  localparam int PCNT_LSB = LEN_W + 8;

  logic              take, flush, busy, stat_ok, stat_more;
  logic [ADDR_W-1:0] byte_addr;
  logic [LEN_W-1:0]  stat_cnt;
  rxce_tag_t         stat_tag, in_tag;
  logic [STAT_W-1:0] stat;

  assign in_tag = '{cls: pkt_class_i, csum_ok: pkt_csum_ok_i};

  always_comb begin
    stat                         = '0;
    stat[LEN_W-1:0]              = stat_cnt;
    stat[FLG_LSB]                = busy;
    stat[FLG_LSB+1]              = stat_ok;
    stat[FLG_LSB+2]              = stat_more;
    stat[FLG_LSB+3 +: 3]         = stat_tag.cls;
    stat[FLG_LSB+6]              = stat_tag.csum_ok;
    stat[PCNT_LSB +: PCNT_W]     = pkt_count_i;
  end

  rxce_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_B(WORD_B)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_i        (cmd_i),
    .pkt_valid_i  (pkt_valid_i),
    .pkt_last_i   (pkt_last_i),
    .pkt_tag_i    (in_tag),
    .flush_done_i (mem_valid_o && mem_ready_i),
    .take_o       (take),
    .ready_o      (pkt_ready_o),
    .byte_addr_o  (byte_addr),
    .flush_o      (flush),
    .busy_o       (busy),
    .ok_o         (stat_ok),
    .more_o       (stat_more),
    .tag_o        (stat_tag),
    .cnt_o        (stat_cnt)
  );

  rxce_packer #(.ADDR_W(ADDR_W), .WORD_B(WORD_B)) u_packer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .byte_addr_i (byte_addr),
    .byte_i      (pkt_data_i),
    .flush_i     (flush),
    .mem_ready_i (mem_ready_i),
    .mem_valid_o (mem_valid_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .mem_strb_o  (mem_strb_o)
  );

  rxce_rdport #(.STAT_W(STAT_W)) u_rdport (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req_i),
    .rd_wait_i   (rd_wait_i),
    .busy_i      (busy),
    .stat_i      (stat),
    .rd_valid_o  (rd_valid_o),
    .rd_status_o (rd_status_o)
  );
endmodule

// File: rtl/rx_copy_engine_chk.sv
module rx_copy_engine_chk #(
  parameter int ADDR_W = 48,
  parameter int LEN_W  = 16,
  parameter int WORD_B = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cmd_valid_i,
  input logic [LEN_W-1:0]    cmd_len_i,
  input logic                busy,
  input logic                stat_ok,
  input logic                pkt_ready_o,
  input logic                mem_valid_o,
  input logic                mem_ready_i,
  input logic [ADDR_W-1:0]   mem_addr_o,
  input logic [WORD_B*8-1:0] mem_data_o,
  input logic [WORD_B-1:0]   mem_strb_o,
  input logic                rd_req_i,
  input logic                rd_wait_i,
  input logic                rd_valid_o,
  input logic                rd_busy_i
);
  localparam int LANE_W = $clog2(WORD_B);

  logic chk_wait;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    chk_wait <= 1'b0;
    else if (rd_valid_o)            chk_wait <= 1'b0;
    else if (rd_req_i && rd_wait_i) chk_wait <= 1'b1;
  end

  assert_word_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_addr_o[LANE_W-1:0] == '0) && (mem_strb_o != '0));

  assert_word_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o)
      && $stable(mem_data_o) && $stable(mem_strb_o));

  assert_drop_clears_ok_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && busy |=> !stat_ok);

  assert_zero_len_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !busy && (cmd_len_i == '0) |=> !busy);

  assert_take_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_ready_o |-> busy && !mem_valid_o);

  assert_wait_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && chk_wait |-> !rd_busy_i);
endmodule

bind rx_copy_engine rx_copy_engine_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .WORD_B(WORD_B)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_len_i   (cmd_i[ADDR_W+LEN_W-1:ADDR_W]),
  .busy        (busy),
  .stat_ok     (stat_ok),
  .pkt_ready_o (pkt_ready_o),
  .mem_valid_o (mem_valid_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_data_o  (mem_data_o),
  .mem_strb_o  (mem_strb_o),
  .rd_req_i    (rd_req_i),
  .rd_wait_i   (rd_wait_i),
  .rd_valid_o  (rd_valid_o),
  .rd_busy_i   (rd_status_o[LEN_W])
);

// File: tb/rx_copy_engine_bench.sv
module rx_copy_engine_bench;
  typedef struct {
    logic [7:0] d;
    bit         last;
    logic [2:0] cls;
    bit         ck;
  } pbyte_t;

  typedef struct {
    logic [47:0] a;
    logic [63:0] d;
    logic [7:0]  s;
  } word_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [63:0] cmd_i = '0;
  logic        rd_req_i = 1'b0, rd_wait_i = 1'b0;
  logic        rd_valid_o;
  logic [63:0] rd_status_o;
  logic        pkt_valid_i = 1'b0, pkt_ready_o;
  logic [7:0]  pkt_data_i = '0;
  logic        pkt_last_i = 1'b0;
  logic [2:0]  pkt_class_i = '0;
  logic        pkt_csum_ok_i = 1'b0;
  logic [7:0]  pkt_count_i = 8'd5;
  logic        mem_valid_o, mem_ready_i = 1'b0;
  logic [47:0] mem_addr_o;
  logic [63:0] mem_data_o;
  logic [7:0]  mem_strb_o;

  always #5 clk = ~clk;

  rx_copy_engine u_rx_copy_engine (.*, .clk_i(clk));

  int     n_chk = 0, n_fail = 0;
  pbyte_t feed_q[$], model_q[$];
  word_t  exp_q[$];
  bit     feed_en = 1'b1, take_prev = 1'b0, hold_prev = 1'b0, done = 1'b0;
  word_t  held;
  logic [15:0] lfsr = 16'hace1;
  int          exp_cnt;
  bit          exp_more, exp_ck;
  logic [2:0]  exp_cls;

  task automatic check(input bit cond, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // stream driver and per-clock memory reference compare
  always @(negedge clk) begin
    if (take_prev) void'(feed_q.pop_front());
    if (feed_en && feed_q.size() > 0) begin
      pkt_valid_i   = 1'b1;
      pkt_data_i    = feed_q[0].d;
      pkt_last_i    = feed_q[0].last;
      pkt_class_i   = feed_q[0].cls;
      pkt_csum_ok_i = feed_q[0].ck;
    end else begin
      pkt_valid_i = 1'b0;
    end
    take_prev = pkt_valid_i && pkt_ready_o;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_ready_i = lfsr[0] | lfsr[3];
    if (hold_prev)
      check(mem_valid_o && mem_addr_o == held.a && mem_data_o == held.d && mem_strb_o == held.s,
            "R14 stalled word held", {16'h0, mem_addr_o}, {16'h0, held.a});
    if (mem_valid_o && mem_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R8 unexpected memory word", {16'h0, mem_addr_o}, 64'h0);
      end else begin
        word_t w;
        w = exp_q.pop_front();
        check(mem_addr_o == w.a, "R2 word address", {16'h0, mem_addr_o}, {16'h0, w.a});
        check(mem_data_o == w.d && mem_strb_o == w.s, "R2 word data/strobe",
              mem_data_o ^ {56'h0, mem_strb_o}, w.d ^ {56'h0, w.s});
      end
    end
    hold_prev = mem_valid_o && !mem_ready_i;
    held = '{mem_addr_o, mem_data_o, mem_strb_o};
  end

  task automatic push_packet(input int len, input logic [7:0] seed, input logic [2:0] cls, input bit ck);
    for (int i = 0; i < len; i++) begin
      pbyte_t b;
      b = '{seed + 8'(i), i == len - 1, cls, ck};
      feed_q.push_back(b);
      model_q.push_back(b);
    end
  endtask

  task automatic expect_copy(input logic [47:0] a, input int len);
    word_t w;
    bit cur = 1'b0, stop = 1'b0;
    exp_cnt = 0;
    for (int i = 0; i < len && model_q.size() > 0 && !stop; i++) begin
      pbyte_t b;
      logic [47:0] x;
      b = model_q.pop_front();
      x = a + 48'(i);
      if (!cur || x[2:0] == 3'd0) begin
        if (cur) exp_q.push_back(w);
        w = '{{x[47:3], 3'b000}, 64'h0, 8'h0};
        cur = 1'b1;
      end
      w.d[x[2:0]*8 +: 8] = b.d;
      w.s[x[2:0]] = 1'b1;
      exp_cnt++;
      exp_more = !b.last;
      exp_cls = b.cls;
      exp_ck = b.ck;
      stop = b.last;
    end
    if (cur) exp_q.push_back(w);
  endtask

  task automatic send_cmd(input logic [47:0] a, input logic [15:0] len);
    @(negedge clk);
    cmd_valid_i = 1'b1;
    cmd_i = {len, a};
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic read_status(input bit w, output logic [63:0] st);
    @(negedge clk);
    rd_req_i = 1'b1;
    rd_wait_i = w;
    @(negedge clk);
    rd_req_i = 1'b0;
    if (!w) check(rd_valid_o, "R11 plain read answers next cycle", {63'h0, rd_valid_o}, 64'h1);
    while (!rd_valid_o) @(negedge clk);
    st = rd_status_o;
  endtask

  task automatic check_done(input string tag, input bit exp_ok);
    logic [63:0] st;
    read_status(1'b1, st);
    check(st[16] == 1'b0, {tag, " R12 wait read shows idle"}, {63'h0, st[16]}, 64'h0);
    check(st[15:0] == 16'(exp_cnt), {tag, " R4 byte count"}, {48'h0, st[15:0]}, 64'(exp_cnt));
    check(st[17] == exp_ok, {tag, " R4/R8 ok flag"}, {63'h0, st[17]}, {63'h0, exp_ok});
    check(st[18] == exp_more, {tag, " R5 more flag"}, {63'h0, st[18]}, {63'h0, exp_more});
    check(st[22:19] == {exp_ck, exp_cls}, {tag, " R6 class/checksum"}, {60'h0, st[22:19]},
          {60'h0, exp_ck, exp_cls});
    check(st[31:24] == pkt_count_i, {tag, " R7 packet count"}, {56'h0, st[31:24]}, {56'h0, pkt_count_i});
    check(exp_q.size() == 0, {tag, " R2 all words written"}, 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'h0, 64'h0);
    finish_run();
  end

  initial begin
    logic [63:0] st;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R13 reset state
    check(!mem_valid_o && !pkt_ready_o && !rd_valid_o, "R13 outputs idle after reset",
          {61'h0, mem_valid_o, pkt_ready_o, rd_valid_o}, 64'h0);
    read_status(1'b0, st);
    check(st[18:0] == '0, "R13 status cleared", {45'h0, st[18:0]}, 64'h0);
    check(st[31:24] == 8'd5, "R7 packet count mirrored", {56'h0, st[31:24]}, 64'd5);

    // R1 R2 R4 R5: aligned, whole packet
    push_packet(20, 8'h10, 3'b011, 1'b1);
    expect_copy(48'h1000, 20);
    send_cmd(48'h1000, 16'd20);
    read_status(1'b0, st);
    check(st[16] == 1'b1, "R1 busy during copy", {63'h0, st[16]}, 64'h1);
    check_done("aligned", 1'b1);

    // R3 R5: unaligned partial copy then remainder with oversize length
    pkt_count_i = 8'd2;
    push_packet(12, 8'h40, 3'b101, 1'b0);
    push_packet(6, 8'h80, 3'b001, 1'b1);
    expect_copy(48'h2003, 5);
    send_cmd(48'h2003, 16'd5);
    check_done("partial", 1'b1);
    expect_copy(48'h3006, 100);
    send_cmd(48'h3006, 16'd100);
    check_done("R3 oversize", 1'b1);
    expect_copy(48'h3100, 6);
    send_cmd(48'h3100, 16'd6);
    check_done("R6 next packet", 1'b1);

    // R8: command while busy dropped
    push_packet(40, 8'hc0, 3'b100, 1'b1);
    expect_copy(48'h4001, 40);
    send_cmd(48'h4001, 16'd40);
    send_cmd(48'h9000, 16'd8);
    check_done("R8 dropped", 1'b0);

    // R9: zero length
    send_cmd(48'h5000, 16'd0);
    read_status(1'b0, st);
    check(st[17:0] == 18'h20000, "R9 zero length done", {46'h0, st[17:0]}, 64'h20000);

    // R10: empty FIFO wait
    feed_en = 1'b0;
    push_packet(9, 8'h20, 3'b010, 1'b0);
    expect_copy(48'h6007, 9);
    send_cmd(48'h6007, 16'd9);
    repeat (8) @(negedge clk);
    check(pkt_ready_o && !mem_valid_o, "R10 waits without writing",
          {62'h0, pkt_ready_o, mem_valid_o}, 64'h2);
    read_status(1'b0, st);
    check(st[16] == 1'b1, "R10 busy while waiting", {63'h0, st[16]}, 64'h1);
    feed_en = 1'b1;
    check_done("R10 resumed", 1'b1);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule